// File: doc/BRIEF.md
# 32-Pin GPIO Bank with Multi-Mode Pin Interrupts

This block is a bank of general-purpose pins that sits on a simple memory-mapped register bus. Software uses a direction register to decide which pins drive and which only sample. An output value register supplies the driven level. Every pin input passes through a two-flop synchronizer before it is read back or used for event detection.

Each pin can raise an event when its synchronized level is low, when it is high, when it rises, or when it falls. Four independent detect registers choose the trigger kinds, and any mix of them may be active on one pin. An event latches into a write-one-to-clear status register only while that pin's interrupt enable is set. A single interrupt line is the OR of every pending status bit whose enable is set.

The output value, interrupt enable and wake-up enable registers can each be loaded whole. Each also has a set alias and a clear alias that change only the bits given in a mask, so concurrent software agents never need a read-modify-write. The wake-up enable bits go straight out to the system power controller.

Top module: `gpio_bank`

The bus reads combinationally: `bus_rdata` follows `bus_addr` in the same cycle. A write takes effect at the rising clock edge on which `bus_en` and `bus_we` are both high. The word addresses are: revision 0, direction 1, input data 2, output value 3, output set 4, output clear 5, interrupt enable 6, enable set 7, enable clear 8, status 9, low-level detect 10, high-level detect 11, rising detect 12, falling detect 13, wake-up enable 14, wake set 15, wake clear 16. The set and clear aliases, and unmapped addresses, read as zero.

## Requirements
- R1: After reset the direction register (address 1) reads all ones. The output value, interrupt enable, wake-up enable, all four detect registers (addresses 10 to 13) and the status register (address 9) read zero, and `irq` is 0.
- R2: A direction bit of 1 makes the pin an input, so its `pin_drive_en` bit is 0. A direction bit of 0 makes the pin drive, so `pin_drive_en` is 1 and `pin_out` carries the output value bit.
- R3: The output value register (address 3) loads the whole word. A write to address 4 sets the masked bits and a write to address 5 clears the masked bits. In both cases every other bit is unchanged.
- R4: The interrupt enable register (address 6) loads the whole word. Address 7 sets the masked bits and address 8 clears them, and every other bit is unchanged.
- R5: The wake-up enable register (address 14) loads the whole word. Address 15 sets the masked bits and address 16 clears them. The register's value is always visible on `wake_en`.
- R6: The input data register (address 2) returns `pin_in` after two synchronizer stages. A change applied before clock edge k is readable after edge k+1 and not after edge k.
- R7: A pin with rising detect (address 12) set latches its status bit when its synchronized value goes 0 to 1. Falling detect (address 13) latches on 1 to 0, and both may be set together. An edge-latched bit stays set until software clears it.
- R8: A status bit can only become set while its interrupt enable bit is 1. `irq` is high exactly when some status bit and its enable bit are both 1, so clearing the enable lowers `irq` but leaves the status bit set.
- R9: High-level detect (address 11) and low-level detect (address 10) keep raising the event while the synchronized pin is at that level. A status bit cleared while its level holds therefore reads 1 again.
- R10: Writing 1 to a status bit clears it and writing 0 has no effect. Writing all ones clears every pending bit that has no new event.
- R11: When a new event and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R12: The revision register (address 0) reads major version in bits 7:4 and minor in bits 3:0 (defaults 2 and 1, so 0x21). Writes to it and to the input data register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high with bus_en |
| bus_addr | input | 5 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output value per pin |
| pin_drive_en | output | 32 | 1 where the pin drives |
| wake_en | output | 32 | Wake-up enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
A stuck or misplaced synchronizer stage shows up as input data or a status bit appearing one edge early or late. The bench checks this on the exact cycle after a pin change. A status register that forgets a latched edge, or that lets a clear beat a simultaneous event, shows at the next status read and on `irq` within one cycle. An alias that disturbs neighbouring bits appears on `pin_out` or `wake_en` right after the write edge. The assertions flag any status bit that rises without its enable, or that drops without a clear, on the cycle it happens.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_REV      = 5'd0,
        REG_DIR      = 5'd1,
        REG_DIN      = 5'd2,
        REG_DOUT     = 5'd3,
        REG_DOUT_SET = 5'd4,
        REG_DOUT_CLR = 5'd5,
        REG_IEN      = 5'd6,
        REG_IEN_SET  = 5'd7,
        REG_IEN_CLR  = 5'd8,
        REG_STAT     = 5'd9,
        REG_DET_LO   = 5'd10,
        REG_DET_HI   = 5'd11,
        REG_DET_RISE = 5'd12,
        REG_DET_FALL = 5'd13,
        REG_WAKE     = 5'd14,
        REG_WAKE_SET = 5'd15,
        REG_WAKE_CLR = 5'd16
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } alias_op_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] smp,
    output logic [N-1:0] prv
);
    logic [N-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else if (s == 0) begin
                    stg[s] <= raw;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    // One more flop keeps the previous synchronized value for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prv <= '0;
        else        prv <= stg[STAGES-1];
    end

    assign smp = stg[STAGES-1];

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int         N   = 32,
    parameter logic [N-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  alias_op_e    op,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else begin
            unique case (op)
                OP_LOAD: q <= wdata;
                OP_SET:  q <= q | wdata;
                OP_CLR:  q <= q & ~wdata;
                default: q <= q;
            endcase
        end
    end

    // R3 R4 R5: a set alias raises the masked bits and keeps the rest
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)) &&
                           ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    // R3 R4 R5: a clear alias drops the masked bits and keeps the rest
    a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLR) |=> ((q & $past(wdata)) == '0) &&
                           ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int N         = 32,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [N-1:0]      din,
    input  logic [N-1:0]      status,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      dout_q,
    output logic [N-1:0]      ien_q,
    output logic [N-1:0]      wake_q,
    output logic [N-1:0]      det_lo,
    output logic [N-1:0]      det_hi,
    output logic [N-1:0]      det_rise,
    output logic [N-1:0]      det_fall,
    output logic [N-1:0]      stat_clr
);
    localparam logic [BUS_W-1:0] REV_WORD =
        BUS_W'({4'(REV_MAJOR), 4'(REV_MINOR)});

    logic          wr;
    reg_sel_e      sel;
    logic [N-1:0]  wd;
    alias_op_e     op_dout, op_ien, op_wake;

    assign wr  = bus_en & bus_we;
    assign sel = reg_sel_e'(bus_addr);
    assign wd  = bus_wdata[N-1:0];

    // Decode one alias triplet into an update operation.
    function automatic alias_op_e pick_op(logic w, reg_sel_e s,
                                          reg_sel_e ld, reg_sel_e st, reg_sel_e cl);
        if (!w)           return OP_HOLD;
        else if (s == ld) return OP_LOAD;
        else if (s == st) return OP_SET;
        else if (s == cl) return OP_CLR;
        else              return OP_HOLD;
    endfunction

    assign op_dout = pick_op(wr, sel, REG_DOUT, REG_DOUT_SET, REG_DOUT_CLR);
    assign op_ien  = pick_op(wr, sel, REG_IEN,  REG_IEN_SET,  REG_IEN_CLR);
    assign op_wake = pick_op(wr, sel, REG_WAKE, REG_WAKE_SET, REG_WAKE_CLR);

    gpio_alias_reg #(.N(N), .RST('0)) u_dout (
        .clk(clk), .rst_n(rst_n), .op(op_dout), .wdata(wd), .q(dout_q));
    gpio_alias_reg #(.N(N), .RST('0)) u_ien (
        .clk(clk), .rst_n(rst_n), .op(op_ien), .wdata(wd), .q(ien_q));
    gpio_alias_reg #(.N(N), .RST('0)) u_wake (
        .clk(clk), .rst_n(rst_n), .op(op_wake), .wdata(wd), .q(wake_q));

    // Plain registers: direction and the four detect selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '1;
            det_lo   <= '0;
            det_hi   <= '0;
            det_rise <= '0;
            det_fall <= '0;
        end else if (wr) begin
            if (sel == REG_DIR)      dir_q    <= wd;
            if (sel == REG_DET_LO)   det_lo   <= wd;
            if (sel == REG_DET_HI)   det_hi   <= wd;
            if (sel == REG_DET_RISE) det_rise <= wd;
            if (sel == REG_DET_FALL) det_fall <= wd;
        end
    end

    assign stat_clr = (wr && sel == REG_STAT) ? wd : '0;

    always_comb begin
        unique case (sel)
            REG_REV:      bus_rdata = REV_WORD;
            REG_DIR:      bus_rdata = BUS_W'(dir_q);
            REG_DIN:      bus_rdata = BUS_W'(din);
            REG_DOUT:     bus_rdata = BUS_W'(dout_q);
            REG_IEN:      bus_rdata = BUS_W'(ien_q);
            REG_STAT:     bus_rdata = BUS_W'(status);
            REG_DET_LO:   bus_rdata = BUS_W'(det_lo);
            REG_DET_HI:   bus_rdata = BUS_W'(det_hi);
            REG_DET_RISE: bus_rdata = BUS_W'(det_rise);
            REG_DET_FALL: bus_rdata = BUS_W'(det_fall);
            REG_WAKE:     bus_rdata = BUS_W'(wake_q);
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] smp,
    input  logic [N-1:0] prv,
    input  logic [N-1:0] det_lo,
    input  logic [N-1:0] det_hi,
    input  logic [N-1:0] det_rise,
    input  logic [N-1:0] det_fall,
    input  logic [N-1:0] ien,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            logic rise_i, fall_i, lvl_i;
            assign rise_i = det_rise[i] &  smp[i] & ~prv[i];
            assign fall_i = det_fall[i] & ~smp[i] &  prv[i];
            assign lvl_i  = (det_hi[i] & smp[i]) | (det_lo[i] & ~smp[i]);
            assign hit[i] = ien[i] & (rise_i | fall_i | lvl_i);
        end
    endgenerate

    // New events override a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | hit;
    end

    assign irq = |(status & ien);

    // R8: a status bit only rises while its enable was set
    a_r8_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(ien)) == '0));

    // R7 R10: a pending bit only drops when software wrote 1 to it
    a_r7_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr) & ~status) == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int SYNC_DEPTH = 2,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_drive_en,
    output logic [NPINS-1:0]  wake_en,
    output logic              irq
);
    logic [NPINS-1:0] smp, prv;
    logic [NPINS-1:0] dir_q, dout_q, ien_q, wake_q;
    logic [NPINS-1:0] det_lo, det_hi, det_rise, det_fall;
    logic [NPINS-1:0] stat_clr, status;

    gpio_sync #(.N(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .smp(smp), .prv(prv));

    gpio_regs #(.N(NPINS), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .din(smp), .status(status),
        .dir_q(dir_q), .dout_q(dout_q), .ien_q(ien_q), .wake_q(wake_q),
        .det_lo(det_lo), .det_hi(det_hi), .det_rise(det_rise), .det_fall(det_fall),
        .stat_clr(stat_clr));

    gpio_evt #(.N(NPINS)) u_evt (
        .clk(clk), .rst_n(rst_n), .smp(smp), .prv(prv),
        .det_lo(det_lo), .det_hi(det_hi), .det_rise(det_rise), .det_fall(det_fall),
        .ien(ien_q), .clr(stat_clr), .status(status), .irq(irq));

    assign pin_out      = dout_q;
    assign pin_drive_en = ~dir_q;
    assign wake_en      = wake_q;

endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    import gpio_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] pin_in, pin_out, pin_drive_en, wake_en;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_drive_en(pin_drive_en),
        .wake_en(wake_en), .irq(irq));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(reg_sel_e a, logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(reg_sel_e a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(REG_DIR, v);      chk("R1 dir", v, 32'hFFFF_FFFF);
        rd(REG_DOUT, v);     chk("R1 dout", v, 32'h0);
        rd(REG_IEN, v);      chk("R1 ien", v, 32'h0);
        rd(REG_WAKE, v);     chk("R1 wake", v, 32'h0);
        rd(REG_STAT, v);     chk("R1 status", v, 32'h0);
        rd(REG_DET_LO, v);   chk("R1 det_lo", v, 32'h0);
        rd(REG_DET_HI, v);   chk("R1 det_hi", v, 32'h0);
        rd(REG_DET_RISE, v); chk("R1 det_rise", v, 32'h0);
        rd(REG_DET_FALL, v); chk("R1 det_fall", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 drive_en", pin_drive_en, 32'h0);
    endtask

    task automatic t_direction();
        wr(REG_DIR, 32'hFFFF_0000);
        chk("R2 drive_en", pin_drive_en, 32'h0000_FFFF);
        wr(REG_DOUT, 32'hA5A5_A5A5);
        chk("R2 pin_out", pin_out, 32'hA5A5_A5A5);
    endtask

    task automatic t_dout();
        logic [31:0] v;
        wr(REG_DOUT, 32'h0000_00F0);
        wr(REG_DOUT_SET, 32'h0F00_0001);
        chk("R3 set alias", pin_out, 32'h0F00_00F1);
        wr(REG_DOUT_CLR, 32'h0000_0030);
        chk("R3 clr alias", pin_out, 32'h0F00_00C1);
        rd(REG_DOUT, v);
        chk("R3 readback", v, 32'h0F00_00C1);
    endtask

    task automatic t_ien();
        logic [31:0] v;
        wr(REG_IEN, 32'h0000_0001);
        wr(REG_IEN_SET, 32'h8000_0000);
        rd(REG_IEN, v); chk("R4 set alias", v, 32'h8000_0001);
        wr(REG_IEN_CLR, 32'h0000_0001);
        rd(REG_IEN, v); chk("R4 clr alias", v, 32'h8000_0000);
        wr(REG_IEN, 32'h0);
    endtask

    task automatic t_wake();
        wr(REG_WAKE, 32'h0000_0003);
        wr(REG_WAKE_SET, 32'h0000_0010);
        chk("R5 set alias", wake_en, 32'h0000_0013);
        wr(REG_WAKE_CLR, 32'h0000_0001);
        chk("R5 clr alias", wake_en, 32'h0000_0012);
    endtask

    task automatic t_din();
        logic [31:0] v;
        pin_in = 32'h1234_5678;
        idle(1);
        rd(REG_DIN, v); chk("R6 not yet", v, 32'h0);
        idle(1);
        rd(REG_DIN, v); chk("R6 after two", v, 32'h1234_5678);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        pin_in = 32'h0; idle(4);
        wr(REG_DET_RISE, 32'h0000_0048);
        wr(REG_DET_FALL, 32'h0000_0060);
        wr(REG_IEN, 32'h0000_0068);
        wr(REG_STAT, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0048; idle(4);
        rd(REG_STAT, v); chk("R7 rise", v, 32'h0000_0048);
        chk("R8 irq high", 32'(irq), 32'h1);
        pin_in = 32'h0; idle(4);
        rd(REG_STAT, v); chk("R7 latched", v, 32'h0000_0048);
        wr(REG_STAT, 32'h0000_0048);
        rd(REG_STAT, v); chk("R10 cleared", v, 32'h0);
        pin_in = 32'h0000_0020; idle(4);
        rd(REG_STAT, v); chk("R7 rise ignored on fall-only", v, 32'h0);
        pin_in = 32'h0; idle(4);
        rd(REG_STAT, v); chk("R7 fall", v, 32'h0000_0020);
        pin_in = 32'h0000_0040; idle(4);
        rd(REG_STAT, v); chk("R7 both kinds", v, 32'h0000_0060);
        wr(REG_STAT, 32'h0);
        rd(REG_STAT, v); chk("R10 zero write", v, 32'h0000_0060);
        wr(REG_STAT, 32'h0000_0020);
        rd(REG_STAT, v); chk("R10 single clear", v, 32'h0000_0040);
        wr(REG_STAT, 32'hFFFF_FFFF);
        rd(REG_STAT, v); chk("R10 all ones", v, 32'h0);
        chk("R8 irq low", 32'(irq), 32'h0);
        pin_in = 32'h0; idle(4);
        wr(REG_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pin_in = 32'h0000_0200; idle(4);
        wr(REG_DET_HI, 32'h0000_0100);
        wr(REG_DET_LO, 32'h0000_0200);
        wr(REG_IEN, 32'h0000_0368);
        idle(2);
        rd(REG_STAT, v); chk("R9 idle levels", v, 32'h0);
        pin_in = 32'h0000_0100; idle(4);
        rd(REG_STAT, v); chk("R9 levels", v, 32'h0000_0300);
        wr(REG_STAT, 32'h0000_0300);
        rd(REG_STAT, v); chk("R9 re-set", v, 32'h0000_0300);
        pin_in = 32'h0000_0200; idle(4);
        wr(REG_STAT, 32'h0000_0300);
        rd(REG_STAT, v); chk("R9 gone", v, 32'h0);
        wr(REG_DET_HI, 32'h0);
        wr(REG_DET_LO, 32'h0);
        wr(REG_IEN, 32'h0000_0068);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        pin_in = 32'h0; idle(4);
        wr(REG_DET_RISE, 32'h0000_1048);
        pin_in = 32'h0000_1000; idle(4);
        rd(REG_STAT, v); chk("R8 disabled no set", v, 32'h0);
        chk("R8 disabled irq", 32'(irq), 32'h0);
        pin_in = 32'h0; idle(4);
        wr(REG_IEN_SET, 32'h0000_1000);
        pin_in = 32'h0000_1000; idle(4);
        rd(REG_STAT, v); chk("R8 enabled set", v, 32'h0000_1000);
        chk("R8 enabled irq", 32'(irq), 32'h1);
        wr(REG_IEN_CLR, 32'h0000_1000);
        chk("R8 irq masked", 32'(irq), 32'h0);
        rd(REG_STAT, v); chk("R8 status kept", v, 32'h0000_1000);
        wr(REG_STAT, 32'hFFFF_FFFF);
        pin_in = 32'h0; idle(4);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        pin_in = 32'h0000_0008; idle(4);
        rd(REG_STAT, v); chk("R11 first latch", v, 32'h0000_0008);
        pin_in = 32'h0; idle(4);
        pin_in = 32'h0000_0008;
        idle(2);
        wr(REG_STAT, 32'h0000_0008);
        rd(REG_STAT, v); chk("R11 set wins", v, 32'h0000_0008);
        idle(2);
        wr(REG_STAT, 32'h0000_0008);
        rd(REG_STAT, v); chk("R11 plain clear", v, 32'h0);
    endtask

    task automatic t_rev();
        logic [31:0] v;
        rd(REG_REV, v); chk("R12 revision", v, 32'h0000_0021);
        wr(REG_REV, 32'hFFFF_FFFF);
        rd(REG_REV, v); chk("R12 rev read-only", v, 32'h0000_0021);
        wr(REG_DIN, 32'hFFFF_FFFF);
        rd(REG_DIN, v); chk("R12 din read-only", v, 32'h0000_0008);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0; pin_in = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_direction();
        t_dout();
        t_ien();
        t_wake();
        t_din();
        t_edge();
        t_level();
        t_gate();
        t_setwins();
        t_rev();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule